// File: doc/BRIEF.md
# Limiter Recovery Gain Controller

This block brings a shared stereo volume code back up toward a programmable reference level after an external limiter has pulled it down. The limiter writes its reduced volume through a load port, optionally tagged as an impulse-type event. From then on the block watches per-sample level flags for each channel and a running waiting timer. Once the signal has stayed below the reset level for the programmed waiting period, it raises the volume by a programmed number of steps, where one step is 0.375 dB.

Each increase is gated by zero crossings seen on every channel since the previous increase. If no crossing arrives, a zero-cross timeout takes over, so the longer of the waiting period and the timeout sets the step rate. The result is a single code that drives both channels. A signal that sits between the reset and detection levels holds the timer at zero, and a signal above the detection level does the same. After an impulse-type event a fast mode shortens the waiting period until the reference is reached again.

Top module: `limiter_recovery_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the volume output loads `cfg_ref`, `step_o` goes low, and the waiting timer, the zero-cross memory and fast mode are all cleared.
- R2: With fast mode off, a step occurs no earlier than the 128·2^`cfg_wait`-th consecutive sample strobe counted from the last restart. A sample strobe counts only if every `lvl_quiet` bit is 1 and every `lvl_over` bit is 0.
- R3: A step raises the volume by `cfg_step`+1 codes, clamped to `cfg_ref`. The volume never exceeds the reference through a step and never wraps around 8 bits.
- R4: While the volume is at or above `cfg_ref`, no step occurs and `step_o` stays low.
- R5: A sample strobe on which any channel has `lvl_quiet`=0, or any channel has `lvl_over`=1, restarts the waiting timer at zero.
- R6: A step needs a `zc_pulse` on every channel since the last step or load. Without one, the step waits until the count also reaches 128·2^`cfg_zto` samples. So when the timeout is shorter than the waiting period, the step happens at the end of the waiting period.
- R7: `lim_load` loads `lim_vol` into the volume at the next edge, takes priority over a step in the same cycle, and restarts the timer and the zero-cross memory.
- R8: A load with `lim_impulse`=1 enters fast mode, in which the waiting period is 128·2^`cfg_wait` shifted right by `cfg_fast_spd`+1. Fast mode ends when a step brings the volume to the reference, or on a load with `lim_impulse`=0.
- R9: `step_o` is high for exactly the one cycle in which the stepped volume first appears, and the timer restarts from zero after each step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | One-cycle strobe per audio sample |
| lvl_over | input | NCH | Per channel: output level at or above the detection level |
| lvl_quiet | input | NCH | Per channel: output level below the reset level |
| zc_pulse | input | NCH | Per channel zero-crossing pulse |
| lim_load | input | 1 | Limiter writes a reduced volume |
| lim_vol | input | VOL_W | Volume written by the limiter |
| lim_impulse | input | 1 | The load comes from an impulse-type event |
| cfg_wait | input | WCODE_W | Waiting period code n: 128·2^n samples |
| cfg_step | input | SCODE_W | Step count minus one |
| cfg_zto | input | ZCODE_W | Zero-cross timeout code k: 128·2^k samples |
| cfg_fast_spd | input | FCODE_W | Fast-mode shortening: waiting period >> (code+1) |
| cfg_ref | input | VOL_W | Reference volume code |
| vol_o | output | VOL_W | Shared volume code for all channels |
| step_o | output | 1 | One-cycle pulse when a step is applied |

## Verification
The hardest condition to reach is a step that arrives exactly at the boundary between the waiting period and the zero-cross timeout, with one channel briefly leaving the quiet band just before the period would expire. Random level flags almost never hold still for hundreds of samples. The bench therefore runs directed stretches of uninterrupted quiet strobes, counted to the sample, with single-sample disturbances placed on purpose, and checks the volume one sample before and at the expected step. Long random phases with rare disturbances and loads are then compared cycle by cycle against a bench model.

// File: rtl/lrg_pkg.sv
package lrg_pkg;
   // Command from the step logic to the waiting timer
   typedef enum logic [1:0] {
      TM_HOLD  = 2'd0,
      TM_ZERO  = 2'd1,
      TM_COUNT = 2'd2
   } tmr_op_e;
endpackage

// File: rtl/lrg_wait_timer.sv
module lrg_wait_timer
   import lrg_pkg::*;
#(
   parameter int BASE_LOG2 = 7,
   parameter int WCODE_W   = 3,
   parameter int ZCODE_W   = 2,
   parameter int FCODE_W   = 2,
   parameter bit FAST_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  tmr_op_e            op,
   input  logic [WCODE_W-1:0] wcode,
   input  logic [ZCODE_W-1:0] zcode,
   input  logic               fast,
   input  logic [FCODE_W-1:0] fspd,
   output logic               wait_done,
   output logic               zto_done
);
   localparam int CNT_W = BASE_LOG2 + (1 << WCODE_W);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   initial begin
      assert (ZCODE_W <= WCODE_W) else $error("timeout code wider than wait code");
      assert (BASE_LOG2 >= (1 << FCODE_W)) else $error("fast shift underflows base period");
   end

   logic [CNT_W-1:0] cnt_q, cnt_inc, wlen_base, wlen, zlen;

   always_comb begin
      cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE;
      wlen_base = ONE << (BASE_LOG2 + int'(wcode));
      zlen      = ONE << (BASE_LOG2 + int'(zcode));
   end

   generate
      if (FAST_EN) begin : g_fast
         always_comb wlen = fast ? (wlen_base >> (int'(fspd) + 1)) : wlen_base;
      end else begin : g_plain
         logic unused_fast;
         always_comb unused_fast = fast ^ (^fspd);
         always_comb wlen = wlen_base;
      end
   endgenerate

   always_comb begin
      wait_done = (cnt_inc >= wlen);
      zto_done  = (cnt_inc >= zlen);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         case (op)
            TM_ZERO:  cnt_q <= '0;
            TM_COUNT: cnt_q <= cnt_inc;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   // R5 / R9: a restart command leaves the count at zero
   a_r5_timer_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TM_ZERO) |=> (cnt_q == '0));
   // R2: counting never wraps back to zero
   a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (op == TM_COUNT) |=> (cnt_q != '0));
endmodule

// File: rtl/lrg_zc_gate.sv
module lrg_zc_gate #(
   parameter int NCH = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] zc,
   input  logic           clr,
   output logic           all_seen
);
   logic [NCH-1:0] seen_q, seen_now;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         always_comb seen_now[c] = seen_q[c] | zc[c];
         always_ff @(posedge clk) begin
            if (!rst_n)   seen_q[c] <= 1'b0;
            else if (clr) seen_q[c] <= 1'b0;
            else          seen_q[c] <= seen_now[c];
         end
      end
   endgenerate

   always_comb all_seen = &seen_now;

   // R6: crossings are forgotten after a step or load
   a_r6_zc_forgotten: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (seen_q == '0));
endmodule

// File: rtl/lrg_vol_reg.sv
module lrg_vol_reg #(
   parameter int VOL_W   = 8,
   parameter int SCODE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VOL_W-1:0]   ref_vol,
   input  logic               ld,
   input  logic [VOL_W-1:0]   ld_val,
   input  logic               imp,
   input  logic               step,
   input  logic [SCODE_W-1:0] scode,
   output logic [VOL_W-1:0]   vol_q,
   output logic               below,
   output logic               fast_q,
   output logic               step_q
);
   initial assert (SCODE_W < VOL_W) else $error("step code too wide");

   logic [VOL_W:0]   sum;
   logic [VOL_W-1:0] nxt;

   always_comb begin
      sum   = {1'b0, vol_q} + {{(VOL_W+1-SCODE_W){1'b0}}, scode} + {{VOL_W{1'b0}}, 1'b1};
      nxt   = (sum > {1'b0, ref_vol}) ? ref_vol : sum[VOL_W-1:0];
      below = (vol_q < ref_vol);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vol_q  <= ref_vol;
         fast_q <= 1'b0;
         step_q <= 1'b0;
      end else if (ld) begin
         vol_q  <= ld_val;
         fast_q <= imp;
         step_q <= 1'b0;
      end else if (step) begin
         vol_q  <= nxt;
         fast_q <= fast_q & (nxt < ref_vol);
         step_q <= 1'b1;
      end else begin
         step_q <= 1'b0;
      end
   end

   // R1: reset loads the reference
   a_r1_reset_ref: assert property (@(posedge clk)
      !rst_n |=> (vol_q == $past(ref_vol)) && !step_q && !fast_q);
   // R3: a step never lands above an unchanged reference
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (step_q && $stable(ref_vol)) |-> (vol_q <= ref_vol));
   // R3: a step always raises the code
   a_r3_rises: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> (vol_q > $past(vol_q)));
   // R4: no step from at or above the reference
   a_r4_hold_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (!below && !ld) |=> !step_q);
   // R7: a load wins over a step
   a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (vol_q == $past(ld_val)) && !step_q);
endmodule

// File: rtl/limiter_recovery_ctrl.sv
module limiter_recovery_ctrl
   import lrg_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int VOL_W     = 8,
   parameter int BASE_LOG2 = 7,
   parameter int WCODE_W   = 3,
   parameter int SCODE_W   = 2,
   parameter int ZCODE_W   = 2,
   parameter int FCODE_W   = 2,
   parameter bit FAST_EN   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_en,
   input  logic [NCH-1:0]     lvl_over,
   input  logic [NCH-1:0]     lvl_quiet,
   input  logic [NCH-1:0]     zc_pulse,
   input  logic               lim_load,
   input  logic [VOL_W-1:0]   lim_vol,
   input  logic               lim_impulse,
   input  logic [WCODE_W-1:0] cfg_wait,
   input  logic [SCODE_W-1:0] cfg_step,
   input  logic [ZCODE_W-1:0] cfg_zto,
   input  logic [FCODE_W-1:0] cfg_fast_spd,
   input  logic [VOL_W-1:0]   cfg_ref,
   output logic [VOL_W-1:0]   vol_o,
   output logic               step_o
);
   initial assert (NCH >= 1) else $error("need at least one channel");

   logic    run, below, fast, wait_done, zto_done, zc_all, step_now;
   tmr_op_e op;

   always_comb begin
      run      = ~(|lvl_over) & (&lvl_quiet);
      step_now = smp_en & run & ~lim_load & below & wait_done & (zc_all | zto_done);
      if (lim_load || step_now)  op = TM_ZERO;
      else if (smp_en && !run)   op = TM_ZERO;
      else if (smp_en)           op = TM_COUNT;
      else                       op = TM_HOLD;
   end

   lrg_wait_timer #(
      .BASE_LOG2(BASE_LOG2), .WCODE_W(WCODE_W), .ZCODE_W(ZCODE_W),
      .FCODE_W(FCODE_W), .FAST_EN(FAST_EN)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .op(op), .wcode(cfg_wait), .zcode(cfg_zto),
      .fast(fast), .fspd(cfg_fast_spd), .wait_done(wait_done), .zto_done(zto_done)
   );

   lrg_zc_gate #(.NCH(NCH)) u_zc (
      .clk(clk), .rst_n(rst_n), .zc(zc_pulse), .clr(lim_load | step_now),
      .all_seen(zc_all)
   );

   lrg_vol_reg #(.VOL_W(VOL_W), .SCODE_W(SCODE_W)) u_vol (
      .clk(clk), .rst_n(rst_n), .ref_vol(cfg_ref), .ld(lim_load), .ld_val(lim_vol),
      .imp(lim_impulse), .step(step_now), .scode(cfg_step), .vol_q(vol_o),
      .below(below), .fast_q(fast), .step_q(step_o)
   );

   // R5: a loud or mid-level sample cannot yield a step at the next edge
   a_r5_loud_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_en && !run && !lim_load) |=> !step_o);
   // R9: step pulses are single-cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |=> !step_o);
endmodule

// File: tb/limiter_recovery_ctrl_test.sv
module limiter_recovery_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n, smp_en, lim_load, lim_impulse;
   logic [1:0] lvl_over, lvl_quiet, zc_pulse;
   logic [7:0] lim_vol, cfg_ref, vol_o;
   logic [2:0] cfg_wait;
   logic [1:0] cfg_step, cfg_zto, cfg_fast_spd;
   logic       step_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   limiter_recovery_ctrl uut (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .lvl_over(lvl_over),
      .lvl_quiet(lvl_quiet), .zc_pulse(zc_pulse), .lim_load(lim_load),
      .lim_vol(lim_vol), .lim_impulse(lim_impulse), .cfg_wait(cfg_wait),
      .cfg_step(cfg_step), .cfg_zto(cfg_zto), .cfg_fast_spd(cfg_fast_spd),
      .cfg_ref(cfg_ref), .vol_o(vol_o), .step_o(step_o)
   );

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // bench model, built from the requirements
   int m_vol, m_cnt, m_fast, m_step;
   bit [1:0] m_seen;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_edge();
      bit [1:0] sn;
      int cn, wl, zl;
      if (!rst_n) begin
         m_vol = cfg_ref; m_cnt = 0; m_seen = 0; m_fast = 0; m_step = 0;
      end else if (lim_load) begin
         m_vol = lim_vol; m_cnt = 0; m_seen = 0; m_fast = lim_impulse; m_step = 0;
      end else begin
         sn = m_seen | zc_pulse;
         m_step = 0;
         if (smp_en) begin
            if (lvl_over != 2'b00 || lvl_quiet != 2'b11) m_cnt = 0;
            else begin
               cn = m_cnt + 1;
               wl = 1 << (7 + cfg_wait);
               if (m_fast != 0) wl = wl >> (cfg_fast_spd + 1);
               zl = 1 << (7 + cfg_zto);
               if (cn >= wl && (sn == 2'b11 || cn >= zl) && m_vol < cfg_ref) begin
                  m_vol = m_vol + cfg_step + 1;
                  if (m_vol >= cfg_ref) begin m_vol = cfg_ref; m_fast = 0; end
                  m_step = 1; m_cnt = 0; sn = 0;
               end else m_cnt = cn;
            end
         end
         m_seen = sn;
      end
   endtask

   // one clock: model the edge, then compare at the following falling edge
   task automatic cyc();
      model_edge();
      @(negedge clk);
      check(vol_o == 8'(m_vol) && step_o == m_step[0], cur_req,
            {vol_o, 7'd0, step_o}, {m_vol[7:0], 7'd0, m_step[0]});
      smp_en = 0; lim_load = 0; lim_impulse = 0; zc_pulse = 0;
      lvl_over = 0; lvl_quiet = 2'b11;
   endtask

   task automatic quiet(input int n, input bit zc_first);
      for (int i = 0; i < n; i++) begin
         smp_en = 1; lvl_quiet = 2'b11; lvl_over = 0;
         zc_pulse = (zc_first && i == 0) ? 2'b11 : 2'b00;
         cyc();
      end
   endtask

   task automatic load(input logic [7:0] v, input bit imp);
      lim_load = 1; lim_vol = v; lim_impulse = imp;
      cyc();
   endtask

   initial begin
      int nsteps;
      void'($urandom(32'd4242));
      rst_n = 0; smp_en = 0; lvl_over = 0; lvl_quiet = 2'b11; zc_pulse = 0;
      lim_load = 0; lim_vol = 0; lim_impulse = 0; cfg_wait = 0; cfg_step = 1;
      cfg_zto = 3; cfg_fast_spd = 0; cfg_ref = 8'h40;
      @(negedge clk);
      cyc(); cyc();
      check(vol_o == 8'h40 && !step_o, "R1", vol_o, 8'h40);
      rst_n = 1;

      // R2 / R3 / R9: 2-step increase after 128 quiet samples with crossings
      cur_req = "R2";
      load(8'h30, 0);
      quiet(127, 1);
      check(vol_o == 8'h30, "R2", vol_o, 8'h30);
      quiet(1, 0);
      check(vol_o == 8'h32 && step_o, "R3", vol_o, 8'h32);
      quiet(1, 0);
      check(!step_o, "R9", step_o, 0);

      // R6: no crossing, timeout 256 longer than wait 128 (count restarted at step)
      cur_req = "R6"; cfg_zto = 1;
      quiet(254, 0);
      check(vol_o == 8'h32, "R6", vol_o, 8'h32);
      quiet(1, 0);
      check(vol_o == 8'h34, "R6", vol_o, 8'h34);
      // R6: timeout 128 shorter than wait 256 -> step at wait end
      cfg_zto = 0; cfg_wait = 1;
      quiet(255, 0);
      check(vol_o == 8'h34, "R6", vol_o, 8'h34);
      quiet(1, 0);
      check(vol_o == 8'h36, "R6", vol_o, 8'h36);

      // R5: mid-level sample on one channel restarts the timer
      cur_req = "R5"; cfg_zto = 3;
      quiet(200, 1);
      smp_en = 1; lvl_quiet = 2'b01; cyc();
      quiet(255, 0);
      check(vol_o == 8'h36, "R5", vol_o, 8'h36);
      quiet(1, 0);
      check(vol_o == 8'h38, "R5", vol_o, 8'h38);
      // R5: above-detection flag restarts as well
      quiet(200, 1);
      smp_en = 1; lvl_over = 2'b10; cyc();
      quiet(255, 0);
      check(vol_o == 8'h38, "R5", vol_o, 8'h38);

      // R3: clamp at reference, R4: hold there
      cur_req = "R3"; cfg_wait = 0; cfg_zto = 0; cfg_step = 3;
      load(8'h3F, 0);
      quiet(128, 0);
      check(vol_o == 8'h40, "R3", vol_o, 8'h40);
      cur_req = "R4"; nsteps = 0;
      for (int i = 0; i < 300; i++) begin quiet(1, 1); nsteps += int'(step_o); end
      check(nsteps == 0 && vol_o == 8'h40, "R4", nsteps, 0);

      // R7: load in the cycle a step would fire
      cur_req = "R7"; cfg_step = 0;
      load(8'h20, 0);
      quiet(127, 1);
      smp_en = 1; lim_load = 1; lim_vol = 8'h21; cyc();
      check(vol_o == 8'h21 && !step_o, "R7", vol_o, 8'h21);

      // R8: fast mode halves the 256-sample wait
      cur_req = "R8"; cfg_wait = 1; cfg_zto = 0; cfg_fast_spd = 0;
      load(8'h10, 1);
      quiet(128, 1);
      check(vol_o == 8'h11, "R8", vol_o, 8'h11);
      load(8'h10, 0);
      quiet(128, 1);
      check(vol_o == 8'h10, "R8", vol_o, 8'h10);
      cfg_fast_spd = 2; load(8'h10, 1);
      quiet(32, 1);
      check(vol_o == 8'h11, "R8", vol_o, 8'h11);

      // random phase against the model
      cur_req = "R9";
      for (int blk = 0; blk < 15; blk++) begin
         cfg_wait = 3'($urandom_range(0, 2)); cfg_zto = 2'($urandom);
         cfg_step = 2'($urandom); cfg_fast_spd = 2'($urandom);
         cfg_ref = 8'($urandom_range(32, 255));
         for (int i = 0; i < 4000; i++) begin
            smp_en = ($urandom_range(0, 3) != 0);
            lvl_quiet = ($urandom_range(0, 299) == 0) ? 2'($urandom) : 2'b11;
            lvl_over = ($urandom_range(0, 499) == 0) ? 2'b01 : 2'b00;
            zc_pulse = {($urandom_range(0, 19) == 0), ($urandom_range(0, 19) == 0)};
            if ($urandom_range(0, 999) == 0) begin
               lim_load = 1; lim_vol = 8'($urandom); lim_impulse = 1'($urandom);
            end
            cyc();
         end
      end

      // R1: reset in the middle of operation
      cur_req = "R1"; cfg_ref = 8'h5A; rst_n = 0; cyc();
      check(vol_o == 8'h5A && !step_o, "R1", vol_o, 8'h5A);
      rst_n = 1; cyc();

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule